// File: doc/BRIEF.md
# CAN Test-Mode Control Register and Pin Steering

This block holds the test control register of a CAN controller and the small amount of logic that steers the controller's transmit and receive signals while a test is running. Software reaches the register over a simple register bus with an address, a write enable, write data and combinational read data. A separate test-enable input, driven from the controller's main control register, decides whether the register may be written and whether any of its settings take effect.

The block sits between the protocol core and the pins. It receives the core's transmit bit, the core's sample-point strobe and the external receive pin. It produces the external transmit pin, the receive bit handed to the core, and a flag that reports when silent operation is in force. With test-enable low, or with every field at zero, the block is transparent: the core drives the transmit pin and hears the receive pin directly.

There are three kinds of test setting. Loopback feeds the core its own transmit bit. Silent operation keeps the bus recessive while the core goes on listening. The pin-source field overrides the transmit pin for hardware test.

Top module: `can_testmode_mux`

## Requirements
- R1: After reset, every writable field reads 0, the transmit pin follows the core transmit bit, the core receive bit follows the receive pin, and the silent flag is 0.
- R2: A write to the register address while test-enable is 1 stores write-data bits 6:5 (pin source), bit 4 (loopback) and bit 3 (silent). The stored values read back at the same bit positions from the next clock onward.
- R3: A write while test-enable is 0 is ignored, and no field changes.
- R4: Read-data bits 31:8 and 2:0 are always 0. Ones written to those bits are dropped.
- R5: Read-data bit 7 shows the receive pin level (0 dominant, 1 recessive) after a two-flop synchronizer. A change on the pin appears there after the second rising clock edge.
- R6: While test-enable is 1, the pin-source field selects the transmit pin: 00 the core transmit bit, 01 the sample-point strobe, 10 a constant 0, 11 a constant 1.
- R7: While test-enable is 1 and loopback is set, the core receive bit equals the core transmit bit, whatever the receive pin does.
- R8: While test-enable is 1, silent is set and the pin source is 00, the transmit pin is 1 and the silent flag is 1. The core still receives from the receive pin. A non-zero pin source takes priority over silent.
- R9: When test-enable is 0, all test functions are inactive in that same cycle. The stored fields are cleared at the next clock edge, so they read 0 after test-enable returns to 1.
- R10: A write to any address other than the register address changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register bus address |
| busWrEn | input | 1 | Register bus write strobe |
| busWrData | input | DATA_W | Register bus write data |
| busRdData | output | DATA_W | Register bus read data (0 when the address does not match) |
| testEn | input | 1 | Test enable from the main control register |
| coreTx | input | 1 | Transmit bit from the protocol core |
| samplePt | input | 1 | Sample-point strobe from the protocol core |
| rxPin | input | 1 | External receive pin |
| txPin | output | 1 | External transmit pin |
| coreRx | output | 1 | Receive bit delivered to the protocol core |
| silentActive | output | 1 | High while silent operation is in force |

## Verification
The assertions assume a known level on rxPin, and stable bus inputs while the reset is active. The synchronizer property also assumes that reset has been released for at least two clock edges before it compares the read-back bit with the pin. The bench changes every input only on the falling clock edge, holds rstN low for several cycles, and leaves rxPin steady around register accesses so that read-back values stay predictable. It moves the pin deliberately only when it is measuring the synchronizer latency.

// File: rtl/can_testmode_pkg.sv
package can_testmode_pkg;

  // Transmit pin source encoding held in the pin-source field
  typedef enum logic [1:0] {
    TX_CORE   = 2'b00,
    TX_SAMPLE = 2'b01,
    TX_DOM    = 2'b10,
    TX_REC    = 2'b11
  } txSrcE;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLoad;   // capture writable fields from write data
    logic fieldClr; // force fields back to reset values
    logic rdSel;    // present register contents on read data
  } tmStrobeT;

  // Field positions (software-visible layout)
  localparam int RX_BIT     = 7;
  localparam int TXSEL_MSB  = 6;
  localparam int TXSEL_LSB  = 5;
  localparam int LOOP_BIT   = 4;
  localparam int SILENT_BIT = 3;

endpackage

// File: rtl/can_tm_ctrl.sv
module can_tm_ctrl
  import can_testmode_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h14)
) (
  input  logic              testEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output tmStrobeT          strobes
);

  logic addrHit;

  always_comb begin
    addrHit          = (busAddr == REG_ADDR);
    strobes.rdSel    = addrHit;
    strobes.fieldClr = !testEn;
    strobes.wrLoad   = testEn && busWrEn && addrHit;
  end

endmodule

// File: rtl/can_tm_dp.sv
module can_tm_dp
  import can_testmode_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmStrobeT          strobes,
  input  logic              testEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              coreTx,
  input  logic              samplePt,
  input  logic              rxPin,
  output logic              txPin,
  output logic              coreRx,
  output logic              silentActive
);

  localparam int SYNC_STAGES = 2;

  txSrcE txSel;
  logic  loopEn;
  logic  silentEn;
  logic [SYNC_STAGES-1:0] rxSyncChain;
  logic  rxSync;
  logic  pinOverride;
  logic  loopActive;

  // Writable fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSel    <= TX_CORE;
      loopEn   <= 1'b0;
      silentEn <= 1'b0;
    end else if (strobes.fieldClr) begin
      txSel    <= TX_CORE;
      loopEn   <= 1'b0;
      silentEn <= 1'b0;
    end else if (strobes.wrLoad) begin
      txSel    <= txSrcE'(busWrData[TXSEL_MSB:TXSEL_LSB]);
      loopEn   <= busWrData[LOOP_BIT];
      silentEn <= busWrData[SILENT_BIT];
    end
  end

  // Receive pin synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSyncChain <= '0;
    else       rxSyncChain <= {rxSyncChain[SYNC_STAGES-2:0], rxPin};
  end
  assign rxSync = rxSyncChain[SYNC_STAGES-1];

  // Pin steering, gated by test enable
  always_comb begin
    pinOverride  = testEn && (txSel != TX_CORE);
    loopActive   = testEn && loopEn;
    silentActive = testEn && silentEn;
    if (pinOverride) begin
      unique case (txSel)
        TX_SAMPLE: txPin = samplePt;
        TX_DOM:    txPin = 1'b0;
        TX_REC:    txPin = 1'b1;
        default:   txPin = coreTx;
      endcase
    end else if (silentActive) begin
      txPin = 1'b1;
    end else begin
      txPin = coreTx;
    end
    coreRx = loopActive ? coreTx : rxPin;
  end

  // Read-back layout
  always_comb begin
    busRdData = '0;
    if (strobes.rdSel) begin
      busRdData[RX_BIT]              = rxSync;
      busRdData[TXSEL_MSB:TXSEL_LSB] = txSel;
      busRdData[LOOP_BIT]            = loopEn;
      busRdData[SILENT_BIT]          = silentEn;
    end
  end

  // Fields are back at reset values one edge after test enable is low
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> (txSel == TX_CORE && !loopEn && !silentEn));

  // Read-back bit tracks the pin two edges later
  assert_rx_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> (rxSync == $past(rxPin, 2)));

endmodule

// File: rtl/can_testmode_mux.sv
module can_testmode_mux
  import can_testmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h14)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              testEn,
  input  logic              coreTx,
  input  logic              samplePt,
  input  logic              rxPin,
  output logic              txPin,
  output logic              coreRx,
  output logic              silentActive
);

  tmStrobeT strobes;

  can_tm_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) ctrl_i (
    .testEn (testEn),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobes(strobes)
  );

  can_tm_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .testEn      (testEn),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .coreTx      (coreTx),
    .samplePt    (samplePt),
    .rxPin       (rxPin),
    .txPin       (txPin),
    .coreRx      (coreRx),
    .silentActive(silentActive)
  );

  localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'('hF8));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & RSVD_MASK) == '0);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (txPin == coreTx && coreRx == rxPin && !silentActive));

  assert_force_rec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && busAddr == REG_ADDR && busRdData[6:5] == 2'b11) |-> txPin);

  assert_force_dom_R6: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && busAddr == REG_ADDR && busRdData[6:5] == 2'b10) |-> !txPin);

  assert_loop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && busAddr == REG_ADDR && busRdData[4]) |-> (coreRx == coreTx));

  assert_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (silentActive && busAddr == REG_ADDR && busRdData[6:5] == 2'b00) |-> txPin);

endmodule

// File: tb/can_testmode_mux_tb.sv
module can_testmode_mux_tb_top;

  localparam logic [7:0] REG = 8'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = REG;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        testEn = 1'b0;
  logic        coreTx = 1'b0;
  logic        samplePt = 1'b0;
  logic        rxPin = 1'b0;
  logic        txPin, coreRx, silentActive;

  always #2 clk = ~clk; // 250 MHz

  can_testmode_mux dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .testEn(testEn),
    .coreTx(coreTx), .samplePt(samplePt), .rxPin(rxPin),
    .txPin(txPin), .coreRx(coreRx), .silentActive(silentActive)
  );

  // Observation kinds: 0 read data, 1 txPin, 2 coreRx, 3 silentActive
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sbItemT;

  sbItemT sbQ[$];
  event   sampleEv;
  int     vecCnt = 0;
  int     errCnt = 0;
  bit     done = 0;

  task automatic expectItem(input int kind, input logic [31:0] exp, input string tag);
    sbItemT it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    #1;
    ->sampleEv;
    #0;
  endtask

  // Monitor: pops expected items and compares with design outputs
  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        sbItemT it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0: act = busRdData;
          1: act = {31'b0, txPin};
          2: act = {31'b0, coreRx};
          default: act = {31'b0, silentActive};
        endcase
        vecCnt++;
        if (act !== it.exp) begin
          errCnt++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = REG; busWrData = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    expectItem(0, 32'h0, "R1 read during reset");
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectItem(0, 32'h0, "R1 fields after reset");
    coreTx = 1'b1;
    expectItem(1, 1, "R1 txPin follows core high");
    coreTx = 1'b0;
    expectItem(1, 0, "R1 txPin follows core low");
    rxPin = 1'b1;
    expectItem(2, 1, "R1 coreRx follows pin");
    expectItem(3, 0, "R1 silent flag low");
    rxPin = 1'b0;
    repeat (3) @(negedge clk);

    // R3: write while test disabled is ignored
    busWrite(REG, 32'h78);
    expectItem(0, 32'h0, "R3 write without test enable");

    // R2 and R4: write all ones with test enabled
    testEn = 1'b1;
    busWrite(REG, 32'hFFFF_FFFF);
    expectItem(0, 32'h78, "R2 R4 all-ones write readback");

    // R10: other address does not touch fields
    busWrite(8'h10, 32'h0);
    expectItem(0, 32'h78, "R10 write to other address");
    busAddr = 8'h10;
    expectItem(0, 32'h0, "R10 other address reads zero");
    busAddr = REG;

    // R6: pin source selection
    busWrite(REG, 32'h20);
    expectItem(0, 32'h20, "R2 sample source readback");
    samplePt = 1'b1; coreTx = 1'b0;
    expectItem(1, 1, "R6 sample point high");
    samplePt = 1'b0; coreTx = 1'b1;
    expectItem(1, 0, "R6 sample point low");
    busWrite(REG, 32'h40);
    coreTx = 1'b1;
    expectItem(1, 0, "R6 forced dominant");
    busWrite(REG, 32'h60);
    coreTx = 1'b0;
    expectItem(1, 1, "R6 forced recessive");
    busWrite(REG, 32'h00);
    coreTx = 1'b1;
    expectItem(1, 1, "R6 core source high");
    coreTx = 1'b0;
    expectItem(1, 0, "R6 core source low");

    // R7: loopback
    busWrite(REG, 32'h10);
    coreTx = 1'b1;
    expectItem(2, 1, "R7 loopback high");
    expectItem(1, 1, "R7 txPin still follows core");
    coreTx = 1'b0; rxPin = 1'b1;
    expectItem(2, 0, "R7 loopback ignores pin");
    rxPin = 1'b0;
    repeat (3) @(negedge clk);

    // R8: silent
    busWrite(REG, 32'h08);
    coreTx = 1'b0;
    expectItem(1, 1, "R8 silent holds recessive");
    expectItem(3, 1, "R8 silent flag");
    rxPin = 1'b1;
    expectItem(2, 1, "R8 core still hears pin");
    rxPin = 1'b0;
    repeat (3) @(negedge clk);
    busWrite(REG, 32'h48);
    coreTx = 1'b1;
    expectItem(1, 0, "R8 override beats silent");

    // R5: synchronizer latency
    busWrite(REG, 32'h00);
    rxPin = 1'b1;
    @(negedge clk);
    expectItem(0, 32'h00, "R5 one edge after pin change");
    @(negedge clk);
    expectItem(0, 32'h80, "R5 two edges after pin change");
    rxPin = 1'b0;
    repeat (3) @(negedge clk);
    expectItem(0, 32'h00, "R5 pin back dominant");

    // R9: dropping test enable
    busWrite(REG, 32'h58);
    testEn = 1'b0; coreTx = 1'b1; rxPin = 1'b0;
    expectItem(1, 1, "R9 txPin back to core at once");
    expectItem(2, 0, "R9 loopback off at once");
    expectItem(3, 0, "R9 silent off at once");
    @(negedge clk);
    expectItem(0, 32'h00, "R9 fields cleared");
    testEn = 1'b1;
    expectItem(0, 32'h00, "R9 fields stay cleared");
    expectItem(1, 1, "R9 no override after re-enable");

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule